// File: doc/BRIEF.md
# Wrapping-Pointer Register Stack

This block is a last-in, first-out store of 64 words of 16 bits each, built entirely from registers. A 6-bit stack pointer, a full flag and an empty flag are held in registers. The flags are never derived from an occupancy counter. They change only when the pointer wraps around to zero.

A push first advances the pointer and then writes the word at the new position. A pop first reads the word at the current position and then steps the pointer back. As a result, location 0 holds the 64th word pushed. One request may arrive per cycle. A popped word is registered and appears one cycle after the pop, marked by a one-cycle valid strobe.

Three requests are refused and change no state:
- a push while the stack is full, which raises an overflow pulse;
- a pop while the stack is empty, which raises an underflow pulse;
- a push and a pop in the same cycle, which raises a conflict pulse.

The fill state is a three-state machine:
- **ST_EMPTY**: the empty flag is set.
- **ST_PARTIAL**: neither flag is set.
- **ST_FULL**: the full flag is set.

Its transitions are:
- **T_FIRST** (ST_EMPTY to ST_PARTIAL): an accepted push.
- **T_FILL** (ST_PARTIAL to ST_FULL): a push whose new pointer is 0.
- **T_DRAIN** (ST_PARTIAL to ST_EMPTY): a pop whose new pointer is 0.
- **T_UNFILL** (ST_FULL to ST_PARTIAL): an accepted pop.
- **T_STAY**: any other request, including every refused one, leaves the state unchanged.

Top module: `lifo_regstack`

## Requirements
- R1: After reset, `sp` is 0, `empty` is 1 and `full` is 0. `pop_valid` and all three error pulses are 0, and `pop_data` is 0.
- R2: An accepted push (`push_req`=1, `pop_req`=0, `full`=0) has these effects one cycle later:
  - `sp` becomes `sp`+1 modulo 64, and the word is stored at that new position;
  - `empty` becomes 0;
  - `full` becomes 1 exactly when the new `sp` is 0.
- R3: An accepted pop (`pop_req`=1, `push_req`=0, `empty`=0) has these effects one cycle later:
  - `pop_data` carries the word stored at the old `sp`, and `pop_valid` is 1 for that one cycle;
  - `sp` becomes `sp`-1 modulo 64;
  - `full` becomes 0;
  - `empty` becomes 1 exactly when the new `sp` is 0.
- R4: 64 accepted pushes from empty leave `sp`=0 and `full`=1, and the 64th word sits at location 0. Whenever `full` or `empty` is 1, `sp` is 0, and the two flags are never both 1.
- R5: Words leave in the reverse order of their arrival, over any mix of pushes and pops.
- R6: A push while `full`=1 (and no pop) is ignored: `sp`, the flags and the contents are unchanged, and `overflow_err` is 1 for one cycle on the next cycle.
- R7: A pop while `empty`=1 (and no push) is ignored: `pop_valid` stays 0, and `underflow_err` is 1 for one cycle on the next cycle.
- R8: A push and a pop in the same cycle change no state whatever the flags are. `conflict_err` is 1 on the next cycle and `pop_valid` stays 0.
- R9: `pop_data` keeps its last value in every cycle that follows no accepted pop.
- R10: Each error output is a one-cycle pulse, and at most one of the three is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push request for this cycle |
| pop_req | input | 1 | Pop request for this cycle |
| push_data | input | 16 | Word to push |
| pop_data | output | 16 | Last word popped, registered |
| pop_valid | output | 1 | `pop_data` was loaded by the pop of the previous cycle |
| sp | output | 6 | Stack pointer |
| full | output | 1 | Full flag |
| empty | output | 1 | Empty flag |
| overflow_err | output | 1 | Pulse: a push was refused because the stack was full |
| underflow_err | output | 1 | Pulse: a pop was refused because the stack was empty |
| conflict_err | output | 1 | Pulse: push and pop were requested together |

## Verification
The bench drives the pointer through its wrap in both directions:
- It fills all 64 entries and checks that location 0 holds the newest word. A design that wrote before incrementing would return the wrong word or lose one entry.
- It pushes against a full stack and pops against an empty one. A design with a missing guard would wrap the pointer and either corrupt the oldest word or raise `pop_valid` with stale data.

It also requests push and pop together in the empty, partial and full states, where a design that gave either request priority would move the pointer. A long pseudo-random mix compares every output on every cycle against a queue model, which catches off-by-one errors in flag timing and data that fails to hold.

// File: rtl/ws_pkg.sv
package ws_pkg;

    // Classification of the request seen in one cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_OVF,
        OP_UNF,
        OP_BOTH
    } op_e;

    // Fill state of the stack
    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PARTIAL,
        ST_FULL
    } fill_e;

endpackage

// File: rtl/ws_decode.sv
module ws_decode
    import ws_pkg::*;
(
    input  logic push_req,
    input  logic pop_req,
    input  logic full,
    input  logic empty,
    output op_e  op
);

    always_comb begin
        op = OP_IDLE;
        if (push_req && pop_req) begin
            op = OP_BOTH;
        end else if (push_req) begin
            op = full ? OP_OVF : OP_PUSH;
        end else if (pop_req) begin
            op = empty ? OP_UNF : OP_POP;
        end
    end

endmodule

// File: rtl/ws_ptr.sv
module ws_ptr
    import ws_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] wr_idx,
    output logic          full,
    output logic          empty
);

    fill_e         state_q;
    fill_e         state_n;
    logic [AW-1:0] ptr_inc;
    logic [AW-1:0] ptr_dec;
    logic          inc_wraps;
    logic          dec_wraps;

    // Carry is dropped, so the last location steps to zero
    assign ptr_inc   = ptr + 1'b1;
    assign ptr_dec   = ptr - 1'b1;
    assign inc_wraps = (ptr_inc == '0);
    assign dec_wraps = (ptr_dec == '0);
    assign wr_idx    = ptr_inc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_n;
        end
    end

    // Pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (op == OP_PUSH) begin
            ptr <= ptr_inc;
        end else if (op == OP_POP) begin
            ptr <= ptr_dec;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (op == OP_PUSH) begin
                    state_n = inc_wraps ? ST_FULL : ST_PARTIAL;   // T_FIRST
                end
            end
            ST_PARTIAL: begin
                if (op == OP_PUSH && inc_wraps) begin
                    state_n = ST_FULL;                            // T_FILL
                end else if (op == OP_POP && dec_wraps) begin
                    state_n = ST_EMPTY;                           // T_DRAIN
                end
            end
            ST_FULL: begin
                if (op == OP_POP) begin
                    state_n = dec_wraps ? ST_EMPTY : ST_PARTIAL;  // T_UNFILL
                end
            end
            default: state_n = ST_EMPTY;
        endcase
    end

    // Flag outputs
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            ST_EMPTY:   empty = 1'b1;
            ST_FULL:    full  = 1'b1;
            ST_PARTIAL: ;
            default:    empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/ws_store.sv
module ws_store #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == AW'(i))) begin
                q <= wr_data;
            end
        end
        assign words[i] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= words[rd_idx];
        end
    end

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
    import ws_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic [AW-1:0] sp,
    output logic          full,
    output logic          empty,
    output logic          overflow_err,
    output logic          underflow_err,
    output logic          conflict_err
);

    op_e           op;
    logic [AW-1:0] wr_idx;

    ws_decode u_dec (
        .push_req (push_req),
        .pop_req  (pop_req),
        .full     (full),
        .empty    (empty),
        .op       (op)
    );

    ws_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .ptr    (sp),
        .wr_idx (wr_idx),
        .full   (full),
        .empty  (empty)
    );

    ws_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op == OP_PUSH),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_en   (op == OP_POP),
        .rd_idx  (sp),
        .rd_data (pop_data)
    );

    // Strobes and error pulses, one cycle after the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_valid     <= 1'b0;
            overflow_err  <= 1'b0;
            underflow_err <= 1'b0;
            conflict_err  <= 1'b0;
        end else begin
            pop_valid     <= (op == OP_POP);
            overflow_err  <= (op == OP_OVF);
            underflow_err <= (op == OP_UNF);
            conflict_err  <= (op == OP_BOTH);
        end
    end

endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          pop_req,
    input logic [DW-1:0] pop_data,
    input logic          pop_valid,
    input logic [AW-1:0] sp,
    input logic          full,
    input logic          empty,
    input logic          overflow_err,
    input logic          underflow_err,
    input logic          conflict_err
);

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !full) |=> (sp == $past(sp) + 1'b1) && !empty); // R2

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !empty) |=> (sp == $past(sp) - 1'b1) && !full && pop_valid); // R3

    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (full || empty) |-> (sp == '0)); // R4

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && full) |=> overflow_err && full && $stable(sp)); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && empty) |=> underflow_err && empty && !pop_valid); // R7

    AST_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req) |=> conflict_err && $stable(sp) && $stable(full) && !pop_valid); // R8

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_req && !push_req && !empty) |=> $stable(pop_data)); // R9

    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow_err, underflow_err, conflict_err})); // R10

endmodule

bind lifo_regstack lifo_regstack_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_req      (push_req),
    .pop_req       (pop_req),
    .pop_data      (pop_data),
    .pop_valid     (pop_valid),
    .sp            (sp),
    .full          (full),
    .empty         (empty),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err),
    .conflict_err  (conflict_err)
);

// File: tb/sim_lifo_regstack.sv
`timescale 1ns/1ps
module sim_lifo_regstack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0;
    logic        pop_req = 1'b0;
    logic [15:0] push_data = '0;
    logic [15:0] pop_data;
    logic        pop_valid;
    logic [5:0]  sp;
    logic        full;
    logic        empty;
    logic        overflow_err;
    logic        underflow_err;
    logic        conflict_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [15:0] model [$];
    int          m_ptr = 0;
    bit          m_full = 0;
    bit          m_empty = 1;
    logic [15:0] m_data = '0;

    always #2.5 clk = ~clk;

    lifo_regstack u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_req      (push_req),
        .pop_req       (pop_req),
        .push_data     (push_data),
        .pop_data      (pop_data),
        .pop_valid     (pop_valid),
        .sp            (sp),
        .full          (full),
        .empty         (empty),
        .overflow_err  (overflow_err),
        .underflow_err (underflow_err),
        .conflict_err  (conflict_err)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, compare at the next falling edge
    task automatic cyc(bit p, bit q, logic [15:0] d, string tag);
        bit e_valid = 0;
        bit e_ovf = 0;
        bit e_unf = 0;
        bit e_conf = 0;
        push_req  = p;
        pop_req   = q;
        push_data = d;
        if (p && q) begin
            e_conf = 1;
        end else if (p) begin
            if (m_full) begin
                e_ovf = 1;
            end else begin
                model.push_back(d);
                m_ptr   = (m_ptr + 1) % 64;
                m_full  = (m_ptr == 0);
                m_empty = 0;
            end
        end else if (q) begin
            if (m_empty) begin
                e_unf = 1;
            end else begin
                m_data  = model.pop_back();
                m_ptr   = (m_ptr + 63) % 64;
                m_empty = (m_ptr == 0);
                m_full  = 0;
                e_valid = 1;
            end
        end
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        chk(tag, "sp", int'(sp), m_ptr);
        chk(tag, "full", int'(full), int'(m_full));
        chk(tag, "empty", int'(empty), int'(m_empty));
        chk(tag, "pop_valid", int'(pop_valid), int'(e_valid));
        chk(tag, "pop_data", int'(pop_data), int'(m_data));
        chk(tag, "overflow_err", int'(overflow_err), int'(e_ovf));
        chk(tag, "underflow_err", int'(underflow_err), int'(e_unf));
        chk(tag, "conflict_err", int'(conflict_err), int'(e_conf));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL all watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "sp", int'(sp), 0);
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "pop_valid", int'(pop_valid), 0);
        chk("R1", "pop_data", int'(pop_data), 0);
        chk("R1", "errors", int'({overflow_err, underflow_err, conflict_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: pop on empty
        cyc(0, 1, 16'h0, "R7");
        // R8: both while empty
        cyc(1, 1, 16'h1111, "R8");
        // R2, R3, R5: small push/pop sequence
        cyc(1, 0, 16'h00A1, "R2");
        cyc(1, 0, 16'h00B2, "R2");
        cyc(1, 0, 16'h00C3, "R2");
        cyc(1, 1, 16'h2222, "R8");
        cyc(0, 0, 16'h0, "R9");
        cyc(0, 1, 16'h0, "R3");
        cyc(0, 0, 16'h0, "R9");
        cyc(0, 1, 16'h0, "R5");
        cyc(0, 1, 16'h0, "R5");
        cyc(0, 1, 16'h0, "R7");

        // R4: fill all entries, the last one lands at location 0
        for (int i = 0; i < 64; i++) begin
            cyc(1, 0, 16'(16'h4000 + i), "R4");
        end
        // R6: pushes while full are ignored
        cyc(1, 0, 16'hDEAD, "R6");
        cyc(1, 0, 16'hBEEF, "R6");
        cyc(1, 1, 16'h3333, "R8");
        // R4/R5: drain in reverse order
        for (int i = 0; i < 64; i++) begin
            cyc(0, 1, 16'h0, "R5");
        end
        cyc(0, 1, 16'h0, "R7");

        // R10: mixed pattern
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[5], lfsr[1] & ~lfsr[7], lfsr, "R10");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule